// File: doc/BRIEF.md
# Interrupt Distributor Control Registers

This block is the small register window at the front of an interrupt distributor. It holds three 32-bit word registers that are reached over a simple strobed register bus. The control register carries the global forwarding enable. The type register reports how large the distributor is, and its value is derived from parameters. The identification register reports fixed product, revision and implementer codes.

The global enable is driven out on `fwd_enable` and gates interrupt forwarding in the logic downstream. When a control write turns forwarding on, the block raises `wake_pulse` for one cycle so that the CPU interfaces re-evaluate their pending state. A write that leaves the enable unchanged does not raise the pulse.

Top module: `irq_dist_ctrl_regs`

## Requirements
- R1: Only address bits [3:2] select the register: 0 selects control, 1 selects type, 2 selects identification, and 3 reads as zero. The other address bits are ignored, so offset 0x10 aliases offset 0x0.
- R2: A read strobe (`req_valid`=1, `req_write`=0) sampled on a clock edge returns `rd_valid`=1 with the data in the following cycle. At all other times `rd_valid` is 0 and `rd_data` is 0.
- R3: Bit 0 of the control register is the global enable. It reads back as written and is driven on `fwd_enable`. Control bits [31:1] read as zero.
- R4: Type bits [4:0] equal (NUM_SHARED + 32) / 32 - 1. With the defaults (96 shared interrupts) this is 3.
- R5: Type bits [7:5] equal NUM_CPUS - 1, and type bits [31:8] read as zero. With the defaults (4 CPUs) the type register reads 0x00000063.
- R6: The identification register reads {PRODUCT_ID[7:0] at bits [31:24], zero at bits [23:16], REVISION[3:0] at bits [15:12], IMPLEMENTER[11:0] at bits [11:0]}. With the defaults it reads 0x4B00243B.
- R7: Writes to the type register, the identification register and offset 0xC change no register, no output and no later read.
- R8: A control write that changes the enable from 0 to 1 raises `wake_pulse` for exactly one cycle. The pulse appears in the same cycle in which `fwd_enable` first reads 1.
- R9: A control write that leaves the enable at 1, or that leaves it at 0, produces no wake pulse.
- R10: Reset clears the enable. During reset and in the first cycle after it, `fwd_enable`, `wake_pulse` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 selects a write, 0 selects a read |
| req_addr | input | ADDR_W | Byte address of the access, word aligned |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 32 | Read data, zero when not valid |
| fwd_enable | output | 1 | Global interrupt forwarding enable |
| wake_pulse | output | 1 | One-cycle pulse when forwarding becomes enabled |

## Verification
The hardest condition to reach from the ports is telling a true enable edge apart from repeated writes that hold the enable at 1. A wake pulse on every control write would look correct if the bench only ever enabled from a cleared state. The stimulus therefore writes 1 twice in a row, then writes all ones while the enable is already set, and then clears the enable and sets it again. It also applies reset while the enable is set and checks that enabling after reset pulses again. Writes aimed at the read-only words and at the unused offset are each followed by reads, so that any corruption of the enable or of the type and identification values would show up at the ports.

// File: rtl/irq_dist_ctrl_regs.sv
module irq_dist_ctrl_regs #(
  parameter int ADDR_W      = 12,
  parameter int NUM_SHARED  = 96,
  parameter int NUM_CPUS    = 4,
  parameter logic [7:0]  PRODUCT_ID  = 8'h4B,
  parameter logic [3:0]  REVISION    = 4'h2,
  parameter logic [11:0] IMPLEMENTER = 12'h43B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              fwd_enable,
  output logic              wake_pulse
);
  localparam int TOTAL_IRQ = NUM_SHARED + 32;
  localparam logic [4:0] LINES_FIELD = 5'((TOTAL_IRQ / 32) - 1);
  localparam logic [2:0] CPUS_FIELD  = 3'(NUM_CPUS - 1);
  localparam logic [31:0] TYPE_WORD  = {24'h0, CPUS_FIELD, LINES_FIELD};
  localparam logic [31:0] IDENT_WORD = {PRODUCT_ID, 8'h00, REVISION, IMPLEMENTER};

  logic [1:0]  sel;
  logic        rd_strobe;
  logic        ctrl_wr;
  logic [31:0] rd_mux;

  assign sel       = req_addr[3:2];
  assign rd_strobe = req_valid && !req_write;
  assign ctrl_wr   = req_valid && req_write && (sel == 2'd0);

  always_comb begin
    case (sel)
      2'd0:    rd_mux = {31'h0, fwd_enable};
      2'd1:    rd_mux = TYPE_WORD;
      2'd2:    rd_mux = IDENT_WORD;
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_enable <= 1'b0;
      wake_pulse <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= 32'h0;
    end else begin
      if (ctrl_wr) fwd_enable <= req_wdata[0];
      wake_pulse <= ctrl_wr && req_wdata[0] && !fwd_enable;
      rd_valid   <= rd_strobe;
      rd_data    <= rd_strobe ? rd_mux : 32'h0;
    end
  end
endmodule

module irq_dist_ctrl_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              fwd_enable,
  input logic              wake_pulse
);
  // R8
  wake_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (fwd_enable && !$past(fwd_enable)));
  // R8
  rise_gives_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_enable) |-> wake_pulse);
  // R2
  rd_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  // R2
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 32'h0));
  // R7
  enable_only_by_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr[3:2] == 2'd0) |=> $stable(fwd_enable));
  // R3
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[3:2] == 2'd0) |=> (rd_data[31:1] == 31'h0));
endmodule

bind irq_dist_ctrl_regs irq_dist_ctrl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .fwd_enable(fwd_enable), .wake_pulse(wake_pulse)
);

// File: tb/irq_dist_ctrl_regs_tb.sv
module irq_dist_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam logic [31:0] TYPE_EXP  = 32'h0000_0063;
  localparam logic [31:0] IDENT_EXP = 32'h4B00_243B;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_wake;
    logic        exp_en;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'h0,         32'h0,     1'b0, 1'b0},
    '{1'b0, 12'h004, 32'h0,         TYPE_EXP,  1'b0, 1'b0},
    '{1'b0, 12'h008, 32'h0,         IDENT_EXP, 1'b0, 1'b0},
    '{1'b0, 12'h00C, 32'h0,         32'h0,     1'b0, 1'b0},
    '{1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0,     1'b0, 1'b0},
    '{1'b0, 12'h004, 32'h0,         TYPE_EXP,  1'b0, 1'b0},
    '{1'b1, 12'h008, 32'h0,         32'h0,     1'b0, 1'b0},
    '{1'b0, 12'h008, 32'h0,         IDENT_EXP, 1'b0, 1'b0},
    '{1'b1, 12'h000, 32'hFFFF_FFFE, 32'h0,     1'b0, 1'b0},
    '{1'b0, 12'h000, 32'h0,         32'h0,     1'b0, 1'b0},
    '{1'b1, 12'h000, 32'h0000_0001, 32'h0,     1'b1, 1'b1},
    '{1'b1, 12'h000, 32'h0000_0001, 32'h0,     1'b0, 1'b1},
    '{1'b0, 12'h000, 32'h0,         32'h1,     1'b0, 1'b1},
    '{1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0,     1'b0, 1'b1},
    '{1'b0, 12'h000, 32'h0,         32'h1,     1'b0, 1'b1},
    '{1'b1, 12'h000, 32'h0,         32'h0,     1'b0, 1'b0},
    '{1'b1, 12'h00C, 32'h0000_0001, 32'h0,     1'b0, 1'b0},
    '{1'b1, 12'h000, 32'h0000_0003, 32'h0,     1'b1, 1'b1},
    '{1'b0, 12'h010, 32'h0,         32'h1,     1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, fwd_enable, wake_pulse;
  logic [31:0] rd_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist_ctrl_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .fwd_enable(fwd_enable), .wake_pulse(wake_pulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic w, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check("R10 enable in reset", {31'h0, fwd_enable}, 32'h0);
    check("R10 wake in reset", {31'h0, wake_pulse}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 12'h0, 32'h0);
    check("R10 rd_valid idle", {31'h0, rd_valid}, 32'h0);
    check("R2 rd_data idle", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i].wr, VEC[i].addr, VEC[i].wdata);
      check("R2 rd_valid", {31'h0, rd_valid}, {31'h0, !VEC[i].wr});
      check("R1 R3 R4 R5 R6 R7 rd_data", rd_data, VEC[i].exp_rd);
      check("R8 R9 wake", {31'h0, wake_pulse}, {31'h0, VEC[i].exp_wake});
      check("R3 R7 enable", {31'h0, fwd_enable}, {31'h0, VEC[i].exp_en});
    end

    step(1'b0, 1'b0, 12'h0, 32'h0);
    check("R8 pulse one cycle", {31'h0, wake_pulse}, 32'h0);
    check("R2 no read after idle", {31'h0, rd_valid}, 32'h0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears enable", {31'h0, fwd_enable}, 32'h0);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 12'h000, 32'h1);
    check("R8 pulse after reset", {31'h0, wake_pulse}, 32'h1);
    step(1'b1, 1'b1, 12'h000, 32'h0);
    check("R9 disable no pulse", {31'h0, wake_pulse}, 32'h0);
    step(1'b1, 1'b1, 12'h000, 32'h0);
    check("R9 stay low no pulse", {31'h0, wake_pulse}, 32'h0);
    check("R3 stays disabled", {31'h0, fwd_enable}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule